// File: doc/BRIEF.md
# Load-Driver Operating Mode Controller

This block decides the operating mode of a multi-channel load-driver chip and gates every channel enable according to that mode. It watches a main-supply-good flag, a logic-supply-good flag, an enable pin and a default-select pin. All of these are asynchronous, so they pass through two-flop synchronizers first. From them the block picks one of four modes: power-off, sleep, normal or default. The mode is shown on a 2-bit code.

The block holds the small control register set that the serial interface writes. It clears that set with a one-cycle reset pulse whenever the chip wakes from power-off or sleep. It keeps the set unchanged when the chip leaves default mode for normal mode.

In normal mode each gate-drive enable is the OR of its register bit and, if direct inputs are allowed, its PWM pin. In default mode the gate drives follow the PWM pins alone, and the on/off switch and constant-current enables are forced low. A loss of the main supply only counts after a run of consecutive low samples of a parameterized length. Shorter drops leave the mode and every register untouched.

Top module: `drv_mode_ctrl`

## Requirements
- R1: While the filtered main supply is absent, mode_o is 2'b00 (power-off), whatever the other pins do.
- R2: With the main supply present, a low enable or a low logic-supply flag gives mode_o = 2'b01 (sleep). In power-off and sleep every drive-side output is 0: gd_en_o, sw_en_o, cc_en_o, cc_pull_o, both DAC codes, ol_cur_o and pwm_ctl_o.
- R3: With the main supply, the logic supply and enable all high, dflt_i high gives mode_o = 2'b11 (default) and dflt_i low gives mode_o = 2'b10 (normal).
- R4: Any move from power-off or sleep into normal or default raises por_o for exactly one clock cycle. In that cycle every control register is returned to its reset value.
- R5: A move from default to normal raises no por_o, and every register keeps its value.
- R6: In default mode, sw_en_o and cc_en_o are 0 and gd_en_o equals the synchronized PWM pins, whatever the gate register bits and the direct-input flag hold.
- R7: Reset values: gate and switch bits 0; direct-input OR flag 1; PWM control flag 0; open-load current flag 1; both current channels off; both pull-ups on; both DAC codes 0.
- R8: The register writes and the normal-mode outputs behave as follows. A write with cfg_we_i high stores cfg_wdata_i into the register picked by cfg_addr_i:
  - 0: gate bits, in [NGD-1:0].
  - 1: switch bits, in [NSW-1:0].
  - 2: flags. Bit 6 is the direct-input OR flag, bit 5 PWM control, bit 4 open-load current, bits 3:2 current-channel on (channel 1 in bit 3), bits 1:0 pull-up (channel 1 in bit 1).
  - 3: DAC codes, channel 0 in [DACW-1:0] and channel 1 in [2*DACW-1:DACW].

  In normal mode gd_en_o = gate bits OR (PWM pins if the OR flag is 1). The other outputs copy their register fields.
- R9: A main-supply drop seen for fewer than FILT consecutive synchronized samples changes neither the mode nor any register. A drop of FILT samples or more moves the chip to power-off and causes a reset on return.
- R10: A change on en_i, logic_ok_i or dflt_i reaches mode_o on the third rising clock edge after it is applied (two synchronizer stages plus the mode register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ok_i | input | 1 | Main supply good, asynchronous |
| logic_ok_i | input | 1 | Logic supply good, asynchronous |
| en_i | input | 1 | Enable pin, asynchronous |
| dflt_i | input | 1 | Default-mode select pin, asynchronous |
| pwm_i | input | NGD | Direct PWM pins for the gate drives |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | DW | Register write data |
| mode_o | output | 2 | 00 off, 01 sleep, 10 normal, 11 default |
| por_o | output | 1 | One-cycle register reset pulse |
| gd_en_o | output | NGD | Gate-drive enables |
| sw_en_o | output | NSW | On/off switch enables |
| cc_en_o | output | 2 | Constant-current channel enables |
| cc_pull_o | output | 2 | Diagnostic pull-up enables |
| cc_dac0_o | output | DACW | Channel 0 DAC code |
| cc_dac1_o | output | DACW | Channel 1 DAC code |
| ol_cur_o | output | 1 | Open-load detect current enable |
| pwm_ctl_o | output | 1 | PWM frequency/duty control enable |

## Verification
The assertions assume that mode_o starts in power-off after reset. They also assume that the synchronized PWM pins are the only source of gate drive in default mode, so a glitch on a PWM pin shorter than a clock is not a violation but is simply sampled. The bench changes every pin on the falling clock edge and holds it for several cycles. Each supply drop is a whole number of cycles long, so the number of low synchronized samples is known exactly. Each pin combination is held longer than the filter window before the mode is checked.

// File: rtl/drv_mode_pkg.sv
package drv_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_NORM  = 2'b10,
    MODE_DFLT  = 2'b11
  } mode_e;

  // Flag register, bit 6 down to bit 0
  typedef struct packed {
    logic       inp_or;
    logic       pwm_ctl;
    logic       ol_cur;
    logic [1:0] cc_on;
    logic [1:0] cc_pull;
  } flags_t;

  localparam flags_t FLAGS_RST = '{inp_or: 1'b1, pwm_ctl: 1'b0, ol_cur: 1'b1,
                                   cc_on: 2'b00, cc_pull: 2'b11};

  function automatic logic is_active(input mode_e m);
    return (m == MODE_NORM) || (m == MODE_DFLT);
  endfunction
endpackage

// File: rtl/drv_sync.sv
module drv_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/drv_supply_filter.sv
module drv_supply_filter #(
  parameter int FILT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_i,
  output logic good_o
);
  localparam int CW = $clog2(FILT + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic [CW-1:0] cnt_q;
  logic          lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lost_q <= 1'b1;
    end else if (ok_i) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else if (!lost_q) begin
      if (cnt_q == LAST) lost_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign good_o = !lost_q;
endmodule

// File: rtl/drv_mode_fsm.sv
module drv_mode_fsm
  import drv_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  main_good_i,
  input  logic  logic_ok_i,
  input  logic  en_i,
  input  logic  dflt_i,
  output mode_e mode_o,
  output logic  por_o
);
  mode_e mode_q, mode_d;
  logic  por_q;

  always_comb begin
    if (!main_good_i)               mode_d = MODE_OFF;
    else if (!logic_ok_i || !en_i)  mode_d = MODE_SLEEP;
    else if (dflt_i)                mode_d = MODE_DFLT;
    else                            mode_d = MODE_NORM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      por_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      por_q  <= !is_active(mode_q) && is_active(mode_d);
    end
  end

  assign mode_o = mode_q;
  assign por_o  = por_q;
endmodule

// File: rtl/drv_cfg_regs.sv
module drv_cfg_regs
  import drv_mode_pkg::*;
#(
  parameter int NGD  = 6,
  parameter int NSW  = 4,
  parameter int DACW = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            we_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [NGD-1:0]  gd_q,
  output logic [NSW-1:0]  sw_q,
  output flags_t          flags_q,
  output logic [DACW-1:0] dac0_q,
  output logic [DACW-1:0] dac1_q
);
  localparam int FW = $bits(flags_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gd_q    <= '0;
      sw_q    <= '0;
      flags_q <= FLAGS_RST;
      dac0_q  <= '0;
      dac1_q  <= '0;
    end else if (clr_i) begin
      gd_q    <= '0;
      sw_q    <= '0;
      flags_q <= FLAGS_RST;
      dac0_q  <= '0;
      dac1_q  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        2'd0: gd_q    <= wdata_i[NGD-1:0];
        2'd1: sw_q    <= wdata_i[NSW-1:0];
        2'd2: flags_q <= flags_t'(wdata_i[FW-1:0]);
        2'd3: begin
          dac0_q <= wdata_i[DACW-1:0];
          dac1_q <= wdata_i[2*DACW-1:DACW];
        end
      endcase
    end
  end
endmodule

// File: rtl/drv_mode_ctrl.sv
module drv_mode_ctrl
  import drv_mode_pkg::*;
#(
  parameter int NGD  = 6,
  parameter int NSW  = 4,
  parameter int DACW = 4,
  parameter int DW   = 8,
  parameter int FILT = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            main_ok_i,
  input  logic            logic_ok_i,
  input  logic            en_i,
  input  logic            dflt_i,
  input  logic [NGD-1:0]  pwm_i,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_addr_i,
  input  logic [DW-1:0]   cfg_wdata_i,
  output logic [1:0]      mode_o,
  output logic            por_o,
  output logic [NGD-1:0]  gd_en_o,
  output logic [NSW-1:0]  sw_en_o,
  output logic [1:0]      cc_en_o,
  output logic [1:0]      cc_pull_o,
  output logic [DACW-1:0] cc_dac0_o,
  output logic [DACW-1:0] cc_dac1_o,
  output logic            ol_cur_o,
  output logic            pwm_ctl_o
);
  localparam int SW = 4 + NGD;

  logic [SW-1:0]   pins_s;
  logic            main_s, logic_s, en_s, dflt_s;
  logic [NGD-1:0]  pwm_s;
  logic            main_good;
  mode_e           mode;
  logic            por;
  logic [NGD-1:0]  gd_q;
  logic [NSW-1:0]  sw_q;
  flags_t          flags_q;
  logic [DACW-1:0] dac0_q, dac1_q;

  drv_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({main_ok_i, logic_ok_i, en_i, dflt_i, pwm_i}),
    .q_o(pins_s)
  );
  assign {main_s, logic_s, en_s, dflt_s, pwm_s} = pins_s;

  drv_supply_filter #(.FILT(FILT)) u_filt (
    .clk(clk), .rst_n(rst_n), .ok_i(main_s), .good_o(main_good)
  );

  drv_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .main_good_i(main_good),
    .logic_ok_i(logic_s), .en_i(en_s), .dflt_i(dflt_s),
    .mode_o(mode), .por_o(por)
  );

  drv_cfg_regs #(.NGD(NGD), .NSW(NSW), .DACW(DACW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .clr_i(por),
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .gd_q(gd_q), .sw_q(sw_q), .flags_q(flags_q),
    .dac0_q(dac0_q), .dac1_q(dac1_q)
  );

  // Output gating by mode
  always_comb begin
    gd_en_o   = '0;
    sw_en_o   = '0;
    cc_en_o   = '0;
    cc_pull_o = '0;
    cc_dac0_o = '0;
    cc_dac1_o = '0;
    ol_cur_o  = 1'b0;
    pwm_ctl_o = 1'b0;
    if (is_active(mode)) begin
      cc_pull_o = flags_q.cc_pull;
      cc_dac0_o = dac0_q;
      cc_dac1_o = dac1_q;
      ol_cur_o  = flags_q.ol_cur;
      pwm_ctl_o = flags_q.pwm_ctl;
    end
    if (mode == MODE_NORM) begin
      gd_en_o = gd_q | (flags_q.inp_or ? pwm_s : '0);
      sw_en_o = sw_q;
      cc_en_o = flags_q.cc_on;
    end else if (mode == MODE_DFLT) begin
      gd_en_o = pwm_s;
    end
  end

  assign mode_o = mode;
  assign por_o  = por;
endmodule

// File: rtl/drv_mode_ctrl_chk.sv
module drv_mode_ctrl_chk #(
  parameter int NGD = 6,
  parameter int NSW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     mode_o,
  input logic           por_o,
  input logic [NGD-1:0] gd_en_o,
  input logic [NSW-1:0] sw_en_o,
  input logic [1:0]     cc_en_o,
  input logic [NGD-1:0] pwm_s
);
  // R4: reset pulse is a single cycle
  a_r4_por_single: assert property (@(posedge clk) disable iff (!rst_n)
    por_o |=> !por_o);

  // R4: reset pulse only on a wake from off or sleep
  a_r4_por_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    por_o |-> (mode_o[1] && !$past(mode_o[1])));

  // R5: default to normal keeps registers
  a_r5_no_por_from_dflt: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == 2'b11 && mode_o == 2'b10) |-> !por_o);

  // R2: no drive in off or sleep
  a_r2_outputs_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_o[1] |-> (gd_en_o == '0 && sw_en_o == '0 && cc_en_o == '0));

  // R6: default mode gating
  a_r6_default_gating: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |-> (sw_en_o == '0 && cc_en_o == '0 && gd_en_o == pwm_s));
endmodule

bind drv_mode_ctrl drv_mode_ctrl_chk #(.NGD(NGD), .NSW(NSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .por_o(por_o),
  .gd_en_o(gd_en_o), .sw_en_o(sw_en_o), .cc_en_o(cc_en_o), .pwm_s(pwm_s)
);

// File: tb/tb_drv_mode_ctrl.sv
`timescale 1ns/1ps
module tb_drv_mode_ctrl;
  localparam int NGD = 6, NSW = 4, DACW = 4, DW = 8, FILT = 8;

  logic clk = 0, rst_n = 0;
  logic main_ok = 0, logic_ok = 0, en = 0, dflt = 0;
  logic [NGD-1:0] pwm = '0;
  logic we = 0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] mode;
  logic por, ol_cur, pwm_ctl;
  logic [NGD-1:0] gd_en;
  logic [NSW-1:0] sw_en;
  logic [1:0] cc_en, cc_pull;
  logic [DACW-1:0] dac0, dac1;

  int checks = 0, errors = 0;
  int por_cnt = 0, por_run = 0, por_max = 0;
  bit done = 0;

  always #10 clk = ~clk;

  drv_mode_ctrl #(.NGD(NGD), .NSW(NSW), .DACW(DACW), .DW(DW), .FILT(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .main_ok_i(main_ok), .logic_ok_i(logic_ok),
    .en_i(en), .dflt_i(dflt), .pwm_i(pwm), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .mode_o(mode), .por_o(por), .gd_en_o(gd_en),
    .sw_en_o(sw_en), .cc_en_o(cc_en), .cc_pull_o(cc_pull), .cc_dac0_o(dac0),
    .cc_dac1_o(dac1), .ol_cur_o(ol_cur), .pwm_ctl_o(pwm_ctl));

  always @(negedge clk) begin
    if (por) begin
      por_cnt++;
      por_run++;
      if (por_run > por_max) por_max = por_run;
    end else por_run = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input logic m, input logic l, input logic e, input logic d);
    main_ok = m; logic_ok = l; en = e; dflt = d;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; we = 1;
    cyc(1);
    we = 0;
  endtask

  function automatic logic [1:0] exp_mode(input logic m, input logic l, input logic e, input logic d);
    if (!m) return 2'b00;
    if (!l || !e) return 2'b01;
    return d ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [31:0] drive_bits();
    return {gd_en, sw_en, cc_en, cc_pull, dac0, dac1, ol_cur, pwm_ctl};
  endfunction

  function automatic logic [31:0] cfg_view();
    return {cc_pull, dac0, dac1, ol_cur, pwm_ctl};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    // Reset state
    chk("R1 reset mode", mode, 2'b00);
    chk("R2 reset outputs", drive_bits(), 0);
    chk("R4 reset por", por, 0);

    // Power up into normal
    pwm = 6'h2A;
    por_cnt = 0; por_max = 0;
    pins(1, 1, 1, 0);
    cyc(FILT + 6);
    chk("R3 normal", mode, 2'b10);
    chk("R4 wake pulses", por_cnt, 1);
    chk("R4 pulse width", por_max, 1);
    chk("R7 reset cfg", cfg_view(), {2'b11, 4'h0, 4'h0, 1'b1, 1'b0});
    chk("R7 gate follows pins", gd_en, 6'h2A);
    chk("R7 switch off", sw_en, 0);
    chk("R7 cc off", cc_en, 0);

    // Normal-mode register control
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h09);
    wr(2'd2, 8'b0111_1101);   // or=1 pwm=1 ol=1 cc_on=11 pull=01
    wr(2'd3, 8'h5A);
    cyc(1);
    chk("R8 gate or", gd_en, 6'h2F);
    chk("R8 switch", sw_en, 4'h9);
    chk("R8 cc on", cc_en, 2'b11);
    chk("R8 fields", cfg_view(), {2'b01, 4'hA, 4'h5, 1'b1, 1'b1});
    wr(2'd2, 8'b0011_1101);   // direct-input OR off
    cyc(1);
    chk("R8 gate reg only", gd_en, 6'h05);
    wr(2'd2, 8'b0111_1101);

    // R10 latency: dflt change seen on the third rising edge
    por_cnt = 0;
    dflt = 1;
    cyc(2);
    chk("R10 before third edge", mode, 2'b10);
    cyc(1);
    chk("R10 on third edge", mode, 2'b11);
    cyc(3);
    chk("R6 gate pins only", gd_en, 6'h2A);
    chk("R6 switch off", sw_en, 0);
    chk("R6 cc off", cc_en, 0);
    chk("R5 cfg held in default", cfg_view(), {2'b01, 4'hA, 4'h5, 1'b1, 1'b1});
    pwm = 6'h13;
    cyc(4);
    chk("R6 gate tracks pins", gd_en, 6'h13);
    dflt = 0;
    cyc(5);
    chk("R5 back to normal", mode, 2'b10);
    chk("R5 no pulse", por_cnt, 0);
    chk("R5 gate kept", gd_en, 6'h17);
    chk("R5 switch kept", sw_en, 4'h9);
    chk("R5 cfg kept", cfg_view(), {2'b01, 4'hA, 4'h5, 1'b1, 1'b1});

    // Sleep then wake into normal: reset
    en = 0;
    cyc(5);
    chk("R2 sleep mode", mode, 2'b01);
    chk("R2 sleep outputs", drive_bits(), 0);
    por_cnt = 0;
    en = 1;
    cyc(5);
    chk("R4 wake from sleep pulse", por_cnt, 1);
    chk("R4 cfg reset", cfg_view(), {2'b11, 4'h0, 4'h0, 1'b1, 1'b0});
    chk("R4 gate reset", gd_en, 6'h13);

    // Sleep then wake into default: reset as well
    wr(2'd3, 8'h77);
    logic_ok = 0;
    cyc(5);
    por_cnt = 0;
    dflt = 1; logic_ok = 1;
    cyc(5);
    chk("R4 wake into default mode", mode, 2'b11);
    chk("R4 wake into default pulse", por_cnt, 1);
    chk("R4 dac reset", {dac1, dac0}, 8'h00);
    dflt = 0;
    cyc(5);

    // Sweep all pin combinations
    pwm = 6'h3F;
    for (int i = 0; i < 16; i++) begin
      pins(i[3], i[2], i[1], i[0]);
      cyc(FILT + 6);
      chk("R1 R3 sweep mode", mode, exp_mode(i[3], i[2], i[1], i[0]));
      if (!mode[1]) chk("R2 sweep outputs off", drive_bits(), 0);
    end

    // Supply drop length sweep
    for (int len = 1; len <= FILT + 2; len++) begin
      pins(1, 1, 1, 0);
      cyc(FILT + 6);
      wr(2'd0, 8'h05);
      wr(2'd3, 8'h5A);
      por_cnt = 0;
      main_ok = 0;
      cyc(len);
      main_ok = 1;
      cyc(FILT + 6);
      chk("R9 mode after drop", mode, 2'b10);
      if (len < FILT) begin
        chk("R9 short drop no pulse", por_cnt, 0);
        chk("R9 short drop dac kept", {dac1, dac0}, 8'h5A);
        chk("R9 short drop gate kept", gd_en, 6'h3F);
      end else begin
        chk("R9 long drop pulse", por_cnt, 1);
        chk("R9 long drop dac reset", {dac1, dac0}, 8'h00);
      end
    end

    // Long loss observed in power-off
    main_ok = 0;
    cyc(FILT + 4);
    chk("R1 lost supply mode", mode, 2'b00);
    chk("R2 lost supply outputs", drive_bits(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule